// File: doc/BRIEF.md
# Clock Source and Machine-Cycle Divider Controller

This block decides which oscillator clocks a small microcontroller core and how many oscillator clocks form one machine cycle. Software writes one 8-bit control word. The block keeps only the field changes that the current state permits, and it reports the live state and two status flags on a read bus. Two clocks are available: a crystal (or external) clock and an internal ring oscillator. Three cycle lengths are available: normal speed of 4 clocks per cycle, slow mode 1 of 64 clocks and slow mode 2 of 1024 clocks. The core advances once on each machine-cycle strobe.

While a slow mode is active, the block can drop back to normal speed by itself when the core signals an accepted interrupt or serial-port activity, provided software has armed this. Software can switch the crystal off while the ring clocks the core. After the crystal is switched on again, a start-up counter must expire before software may select the crystal. The analog oscillators and the glitch-free clock mux are not part of this block. They appear only as the `clk_sel_xtal` and `xtal_en` select outputs.

Top module: `ckm_ctrl`

## Requirements
- R1: After reset the read word is 8'h45: crystal selected, crystal enabled, divider code 01, switchback disarmed, ring-status 0, crystal-stable 1. `clk_sel_xtal`=1 and `xtal_en`=1.
- R2: Read layout: bit0 source (1 = crystal), bit1 crystal-off, bits 3:2 divider code, bit4 switchback-arm, bit5 ring-status, bit6 crystal-stable, bit7 zero. A write with bit0=0 always selects the ring. Ring-status then reads 1 and `clk_sel_xtal` reads 0.
- R3: A write that changes the source from 0 to 1 is kept only while crystal-stable is 1 and crystal-off is 0. Otherwise the source stays 0.
- R4: Crystal-off can be set to 1 only while the ring is selected both before and after the write. Writing it to 0 is always kept.
- R5: Divider codes 01, 10 and 11 give one `cyc_stb` pulse every 4, 64 and 1024 clocks respectively.
- R6: A write of code 01 is always kept. Codes 10 and 11 are kept only when the current code is 01. Code 00 is never kept.
- R7: The switchback-arm bit can be written at any time. While it reads 1, a cycle with `sb_evt` high forces the code to 01 at the next edge, and this overrides a write in the same cycle. While it reads 0, `sb_evt` has no effect.
- R8: Crystal-stable reads 0 from the cycle after crystal-off reads 1. Once crystal-off is 0 again, it returns to 1 after STARTUP_CYC consecutive clocks with `xtal_lock` high. A low `xtal_lock` restarts that count.
- R9: Any change of divider code restarts the cycle counter. The first `cyc_stb` of the new mode comes one full period after the change edge.
- R10: `xtal_en` is the inverse of the crystal-off bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 8 | Control word to write (layout as in R2) |
| sb_evt | input | 1 | Switchback event: accepted interrupt or serial activity |
| xtal_lock | input | 1 | Crystal oscillator reports that it is running |
| rd_data | output | 8 | Control and status read word |
| clk_sel_xtal | output | 1 | Clock mux select, 1 = crystal |
| xtal_en | output | 1 | Crystal oscillator enable |
| cyc_stb | output | 1 | One-clock machine-cycle strobe |

## Verification
The divider write rules are swept over every pair of current code (01, 10, 11) and requested code (00 to 11). This separates the accept-from-01-only rule from the always-accept rule for 01 and from rejection of 00. The strobe spacing and the delay to the first strobe after a change are measured in each mode, which catches a wrong divisor or a counter that does not restart. The source and crystal-off guards are tried in each combination of current source, crystal-off and crystal-stable. The start-up timer is run once with the lock held low and once with the lock high, which separates a timer that waits for the lock from one that counts freely. The switchback is tried disarmed, armed, and armed together with a conflicting write.

// File: rtl/ckm_pkg.sv
package ckm_pkg;

  typedef enum logic [1:0] {
    DIV_RSVD  = 2'b00,
    DIV_NORM  = 2'b01,
    DIV_SLOW1 = 2'b10,
    DIV_SLOW2 = 2'b11
  } div_mode_e;

  localparam int unsigned REG_W   = 8;
  localparam int unsigned B_SRC   = 0;
  localparam int unsigned B_XOFF  = 1;
  localparam int unsigned B_DIVLO = 2;
  localparam int unsigned B_SBEN  = 4;
  localparam int unsigned B_RING  = 5;
  localparam int unsigned B_XOK   = 6;

  // Slow codes need the normal mode as the starting point; 01 is always fine.
  function automatic logic div_write_ok(input div_mode_e cur, input logic [1:0] req);
    return (req == DIV_NORM) || (req[1] && (cur == DIV_NORM));
  endfunction

  // Clocks per machine cycle for a code.
  function automatic int unsigned div_len(input div_mode_e m, input int unsigned n_norm,
                                          input int unsigned n_s1, input int unsigned n_s2);
    case (m)
      DIV_SLOW1: return n_s1;
      DIV_SLOW2: return n_s2;
      default:   return n_norm;
    endcase
  endfunction

endpackage

// File: rtl/ckm_regs.sv
module ckm_regs
  import ckm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             sb_evt,
  input  logic             xtal_ok,
  output logic             src_xtal,
  output logic             xoff,
  output div_mode_e        div_mode,
  output logic             sb_en,
  output logic             sb_fire,
  output logic             div_restart
);

  logic      src_n, xoff_n, sb_n;
  div_mode_e div_n;

  always_comb begin
    src_n = src_xtal;
    xoff_n = xoff;
    div_n = div_mode;
    sb_n = sb_en;
    if (wr_en) begin
      sb_n = wr_data[B_SBEN];
      if (!wr_data[B_SRC])
        src_n = 1'b0;
      else if (src_xtal || (xtal_ok && !xoff))
        src_n = 1'b1;
      if (!wr_data[B_XOFF])
        xoff_n = 1'b0;
      else if (!src_xtal && !src_n)
        xoff_n = 1'b1;
      if (div_write_ok(div_mode, wr_data[B_DIVLO+1:B_DIVLO]))
        div_n = div_mode_e'(wr_data[B_DIVLO+1:B_DIVLO]);
    end
    sb_fire = sb_en && sb_evt;
    if (sb_fire)
      div_n = DIV_NORM;
    div_restart = (div_n != div_mode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_xtal <= 1'b1;
      xoff     <= 1'b0;
      div_mode <= DIV_NORM;
      sb_en    <= 1'b0;
    end else begin
      src_xtal <= src_n;
      xoff     <= xoff_n;
      div_mode <= div_n;
      sb_en    <= sb_n;
    end
  end

endmodule

// File: rtl/ckm_xtal_timer.sv
module ckm_xtal_timer #(
  parameter int unsigned STARTUP_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xoff,
  input  logic xtal_lock,
  output logic xtal_ok
);

  localparam int unsigned TW = $clog2(STARTUP_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(STARTUP_CYC - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      xtal_ok <= 1'b1;
    end else if (xoff) begin
      cnt     <= '0;
      xtal_ok <= 1'b0;
    end else if (!xtal_ok) begin
      if (!xtal_lock)
        cnt <= '0;
      else if (cnt == LAST)
        xtal_ok <= 1'b1;
      else
        cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/ckm_prescaler.sv
module ckm_prescaler
  import ckm_pkg::*;
#(
  parameter int unsigned N_NORM  = 4,
  parameter int unsigned N_SLOW1 = 64,
  parameter int unsigned N_SLOW2 = 1024
) (
  input  logic      clk,
  input  logic      rst_n,
  input  div_mode_e div_mode,
  input  logic      restart,
  output logic      cyc_stb
);

  localparam int unsigned NMAX  = (N_SLOW2 > N_SLOW1) ? N_SLOW2 : N_SLOW1;
  localparam int unsigned CNT_W = $clog2(NMAX);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  assign last    = CNT_W'(div_len(div_mode, N_NORM, N_SLOW1, N_SLOW2) - 1);
  assign cyc_stb = (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (restart || cyc_stb)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/ckm_ctrl.sv
module ckm_ctrl
  import ckm_pkg::*;
#(
  parameter int unsigned N_NORM      = 4,
  parameter int unsigned N_SLOW1     = 64,
  parameter int unsigned N_SLOW2     = 1024,
  parameter int unsigned STARTUP_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       sb_evt,
  input  logic       xtal_lock,
  output logic [7:0] rd_data,
  output logic       clk_sel_xtal,
  output logic       xtal_en,
  output logic       cyc_stb
);

  logic      src_xtal, xoff, sb_en, sb_fire, div_restart, xtal_ok;
  div_mode_e div_mode;

  ckm_regs i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .sb_evt(sb_evt), .xtal_ok(xtal_ok), .src_xtal(src_xtal), .xoff(xoff),
    .div_mode(div_mode), .sb_en(sb_en), .sb_fire(sb_fire),
    .div_restart(div_restart)
  );

  ckm_xtal_timer #(.STARTUP_CYC(STARTUP_CYC)) i_timer (
    .clk(clk), .rst_n(rst_n), .xoff(xoff), .xtal_lock(xtal_lock),
    .xtal_ok(xtal_ok)
  );

  ckm_prescaler #(.N_NORM(N_NORM), .N_SLOW1(N_SLOW1), .N_SLOW2(N_SLOW2)) i_presc (
    .clk(clk), .rst_n(rst_n), .div_mode(div_mode), .restart(div_restart),
    .cyc_stb(cyc_stb)
  );

  always_comb begin
    rd_data                      = '0;
    rd_data[B_SRC]               = src_xtal;
    rd_data[B_XOFF]              = xoff;
    rd_data[B_DIVLO+1:B_DIVLO]   = div_mode;
    rd_data[B_SBEN]              = sb_en;
    rd_data[B_RING]              = !src_xtal;
    rd_data[B_XOK]               = xtal_ok;
  end

  assign clk_sel_xtal = src_xtal;
  assign xtal_en      = !xoff;

endmodule

// File: rtl/ckm_ctrl_chk.sv
module ckm_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] rd_data,
  input logic       sb_evt,
  input logic       cyc_stb,
  input logic       div_restart
);

  logic       src, xoff, sben, ok;
  logic [1:0] div;
  assign src  = rd_data[0];
  assign xoff = rd_data[1];
  assign div  = rd_data[3:2];
  assign sben = rd_data[4];
  assign ok   = rd_data[6];

  a_r3_src_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (!src && !(ok && !xoff)) |=> !src);

  a_r4_xoff_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (src && !xoff) |=> !xoff);

  a_r6_slow_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (div != 2'b01) |=> (div == 2'b01 || div == $past(div)));

  a_r7_switchback: assert property (@(posedge clk) disable iff (!rst_n)
    (sben && sb_evt) |=> (div == 2'b01));

  a_r8_xtal_drop: assert property (@(posedge clk) disable iff (!rst_n)
    xoff |=> !ok);

  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    div_restart |=> !cyc_stb);

endmodule

bind ckm_ctrl ckm_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .sb_evt(sb_evt),
  .cyc_stb(cyc_stb), .div_restart(div_restart)
);

// File: tb/test_ckm_ctrl.sv
`timescale 1ns/1ps
module test_ckm_ctrl;

  localparam int STARTUP = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       sb_evt = 1'b0;
  logic       xtal_lock = 1'b1;
  logic [7:0] rd_data;
  logic       clk_sel_xtal, xtal_en, cyc_stb;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ckm_ctrl #(.STARTUP_CYC(STARTUP)) i_ckm_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .sb_evt(sb_evt), .xtal_lock(xtal_lock), .rd_data(rd_data),
    .clk_sel_xtal(clk_sel_xtal), .xtal_en(xtal_en), .cyc_stb(cyc_stb)
  );

  function automatic int period_of(input int code);
    return 4 * (16 ** (code - 1));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic ev);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; sb_evt = ev;
    @(negedge clk);
    wr_en = 1'b0; sb_evt = 1'b0;
  endtask

  task automatic pulse_evt();
    @(negedge clk);
    sb_evt = 1'b1;
    @(negedge clk);
    sb_evt = 1'b0;
  endtask

  task automatic count_to_stb(output int n);
    n = 0;
    while (!cyc_stb) begin @(negedge clk); n++; end
  endtask

  task automatic interval(output int n);
    n = 1;
    @(negedge clk);
    while (!cyc_stb) begin @(negedge clk); n++; end
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rd_data", rd_data, 8'h45);
    chk("R1 clk_sel", clk_sel_xtal, 1);
    chk("R10 xtal_en", xtal_en, 1);

    // R6 exhaustive write-rule sweep, R5/R9 timing per mode
    for (int from = 1; from <= 3; from++) begin
      for (int to = 0; to <= 3; to++) begin
        wr(8'h05, 1'b0);
        wr(8'h01 | 8'(from << 2), 1'b0);
        chk("R6 setup", rd_data[3:2], from);
        wr(8'h01 | 8'(to << 2), 1'b0);
        exp = (to == 1) ? 1 : ((to >= 2 && from == 1) ? to : from);
        chk("R6 write rule", rd_data[3:2], exp);
      end
    end
    for (int code = 3; code >= 1; code--) begin
      wr(8'h05, 1'b0);
      wr(8'h01 | 8'(code << 2), 1'b0);
      if (code != 1) begin
        count_to_stb(n);
        chk("R9 first strobe", n, period_of(code) - 1);
      end else
        count_to_stb(n);
      interval(n);
      chk("R5 period", n, period_of(code));
      interval(n);
      chk("R5 period repeat", n, period_of(code));
    end

    // R7 switchback
    wr(8'h09, 1'b0);
    pulse_evt();
    chk("R7 disarmed no effect", rd_data[3:2], 2);
    wr(8'h19, 1'b0);
    chk("R7 arm", rd_data[4], 1);
    chk("R7 arm keeps mode", rd_data[3:2], 2);
    pulse_evt();
    chk("R7 switchback", rd_data[3:2], 1);
    wr(8'h1D, 1'b1);
    chk("R7 overrides write", rd_data[3:2], 1);
    wr(8'h05, 1'b0);
    chk("R7 disarm", rd_data[4], 0);

    // R4 crystal-off refused while crystal selected
    wr(8'h07, 1'b0);
    chk("R4 xoff refused", rd_data[1], 0);
    chk("R3 src kept", rd_data[0], 1);
    // R2 select ring
    wr(8'h04, 1'b0);
    chk("R2 src", rd_data[0], 0);
    chk("R2 ring status", rd_data[5], 1);
    chk("R2 clk_sel", clk_sel_xtal, 0);
    wr(8'h06, 1'b0);
    chk("R4 xoff set", rd_data[1], 1);
    chk("R10 xtal_en off", xtal_en, 0);
    @(negedge clk);
    chk("R8 stable cleared", rd_data[6], 0);
    wr(8'h07, 1'b0);
    chk("R3 refused while off", rd_data[0], 0);
    xtal_lock = 1'b0;
    wr(8'h04, 1'b0);
    chk("R4 xoff clear", rd_data[1], 0);
    wr(8'h05, 1'b0);
    chk("R3 refused while unstable", rd_data[0], 0);
    repeat (40) @(negedge clk);
    chk("R8 waits for lock", rd_data[6], 0);
    xtal_lock = 1'b1;
    n = 0;
    while (!rd_data[6] && n < 100) begin @(negedge clk); n++; end
    chk("R8 startup count", n, STARTUP);
    wr(8'h05, 1'b0);
    chk("R3 accepted when stable", rd_data[0], 1);
    chk("R2 ring status back", rd_data[5], 0);
    chk("R2 clk_sel back", clk_sel_xtal, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule